// File: doc/BRIEF.md
# Conflict-Aware Memory Port Arbiter

This block decides which of N requesters may use a single shared memory port in the current cycle. Each requester offers at most one operation per cycle, made of a valid bit, a write flag and an address. A separate busy input describes an operation that already occupies the memory. Any request that would clash with that busy operation is removed before the selection runs. A clash means the same address with at least one of the two sides writing.

One of the remaining requests is granted in the same cycle. A parameter fixes the selection policy at build time. In fixed mode the lowest-numbered port always wins. In rotating mode the search starts just after the port that was granted last, so blocked and idle ports are passed over. The granted operation is forwarded unchanged on the output side and goes to the memory controller. The only state in the block is the rotation pointer.

Top module: `mem_port_arbiter`

## Requirements
- R1: A port whose `req_valid` bit is 0 is never granted.
- R2: `grant` and the forwarded operation depend only on the current-cycle inputs and the rotation pointer; a request is answered in the cycle it is presented, with no register in between.
- R3: While `busy_valid` is 1, a request with `req_addr` equal to `busy_addr` is not eligible when `busy_write` is 1, when its own write flag is 1, or when both are 1.
- R4: A request whose address differs from `busy_addr` is never blocked by the busy operation. When `busy_valid` is 0, no request is blocked.
- R5: A read request to the same address as a busy read stays eligible.
- R6: `fwd_valid`, `fwd_write` and `fwd_addr` equal the granted port's operation. `fwd_valid` is 0 when nothing is granted, including the case where every valid request is blocked.
- R7: In fixed mode (`MODE` = ARB_FIXED), the eligible port with the lowest index is granted, whether the requests are reads or writes.
- R8: In rotating mode (`MODE` = ARB_ROTATE), after port k is granted the next search starts at port k+1 and wraps from N-1 to 0.
- R9: In rotating mode, blocked ports are skipped. Ports 0 to 3 all request and port 2 is blocked, starting with the pointer at 0. The grants then run 0, 1, 3, 0, 1.
- R10: The rotation pointer moves only in cycles that issue a grant. After reset, port 0 is searched first.
- R11: `grant` is an N-bit vector with bit i for port i. At most one bit is set. A bit is set whenever at least one request is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the rotation pointer |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N | Per-port request present |
| req_write | input | N | Per-port write flag (1 = write, 0 = read) |
| req_addr | input | N*AW | Per-port addresses; port i occupies bits [i*AW +: AW] |
| busy_valid | input | 1 | An operation is occupying the memory |
| busy_write | input | 1 | Write flag of the occupying operation |
| busy_addr | input | AW | Address of the occupying operation |
| grant | output | N | One-hot grant, bit i for port i |
| fwd_valid | output | 1 | Forwarded operation present |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_addr | output | AW | Forwarded address |

## Verification
The fixed-mode instance receives single requests on each port. This shows that the grant and forwarded fields come from the right port. Overlapping read and write mixes show that priority follows the index alone. Busy operations are then combined with matching and differing addresses and every read/write pairing, which separates a correct clash test from one that ignores the write flags or the address. The rotating instance runs full-load sequences, idle gaps, a blocked port and a sparse request set that needs wrap-around. Together these show the pointer advance, its hold when nothing is granted, and the skipping of blocked ports.

// File: rtl/mem_arb_pkg.sv
`timescale 1ns/1ps
package mem_arb_pkg;

    typedef enum logic {
        ARB_FIXED  = 1'b0,
        ARB_ROTATE = 1'b1
    } arb_mode_e;

endpackage

// File: rtl/arb_clash_filter.sv
`timescale 1ns/1ps
module arb_clash_filter #(
    parameter int N  = 4,
    parameter int AW = 8
) (
    input  logic [N-1:0]    req_valid,
    input  logic [N-1:0]    req_write,
    input  logic [N*AW-1:0] req_addr,
    input  logic            busy_valid,
    input  logic            busy_write,
    input  logic [AW-1:0]   busy_addr,
    output logic [N-1:0]    eligible
);

    for (genvar i = 0; i < N; i++) begin : g_port
        logic same_addr;
        logic any_write;
        always_comb begin
            same_addr   = (req_addr[i*AW +: AW] == busy_addr);
            any_write   = busy_write | req_write[i];
            eligible[i] = req_valid[i] & ~(busy_valid & same_addr & any_write);
        end
    end

endmodule

// File: rtl/arb_pick.sv
`timescale 1ns/1ps
module arb_pick #(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input  logic [N-1:0]  eligible,
    input  logic [PW-1:0] start,
    output logic [N-1:0]  grant,
    output logic [PW-1:0] grant_idx,
    output logic          any
);

    always_comb begin
        int  pos;
        grant     = '0;
        grant_idx = '0;
        any       = 1'b0;
        for (int k = 0; k < N; k++) begin
            pos = int'(start) + k;
            if (pos >= N) pos = pos - N;
            if (!any && eligible[pos]) begin
                any        = 1'b1;
                grant[pos] = 1'b1;
                grant_idx  = PW'(pos);
            end
        end
    end

endmodule

// File: rtl/arb_op_mux.sv
`timescale 1ns/1ps
module arb_op_mux #(
    parameter int N  = 4,
    parameter int AW = 8
) (
    input  logic [N-1:0]    grant,
    input  logic [N-1:0]    req_write,
    input  logic [N*AW-1:0] req_addr,
    output logic            fwd_write,
    output logic [AW-1:0]   fwd_addr
);

    always_comb begin
        fwd_write = 1'b0;
        fwd_addr  = '0;
        for (int i = 0; i < N; i++) begin
            fwd_write = fwd_write | (grant[i] & req_write[i]);
            fwd_addr  = fwd_addr  | ({AW{grant[i]}} & req_addr[i*AW +: AW]);
        end
    end

endmodule

// File: rtl/mem_port_arbiter.sv
`timescale 1ns/1ps
module mem_port_arbiter
    import mem_arb_pkg::*;
#(
    parameter int        N    = 4,
    parameter int        AW   = 8,
    parameter arb_mode_e MODE = ARB_ROTATE
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req_valid,
    input  logic [N-1:0]    req_write,
    input  logic [N*AW-1:0] req_addr,
    input  logic            busy_valid,
    input  logic            busy_write,
    input  logic [AW-1:0]   busy_addr,
    output logic [N-1:0]    grant,
    output logic            fwd_valid,
    output logic            fwd_write,
    output logic [AW-1:0]   fwd_addr
);

    localparam int PW = (N > 1) ? $clog2(N) : 1;
    localparam logic [PW-1:0] LAST = PW'(N - 1);

    typedef struct packed {
        logic [PW-1:0] ptr;
    } state_t;

    state_t        st_d, st_q;
    logic [N-1:0]  eligible;
    logic [PW-1:0] start;
    logic [PW-1:0] grant_idx;
    logic          any_grant;

    arb_clash_filter #(.N(N), .AW(AW)) u_filter (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .busy_valid (busy_valid),
        .busy_write (busy_write),
        .busy_addr  (busy_addr),
        .eligible   (eligible)
    );

    always_comb start = (MODE == ARB_ROTATE) ? st_q.ptr : '0;

    arb_pick #(.N(N), .PW(PW)) u_pick (
        .eligible  (eligible),
        .start     (start),
        .grant     (grant),
        .grant_idx (grant_idx),
        .any       (any_grant)
    );

    arb_op_mux #(.N(N), .AW(AW)) u_mux (
        .grant     (grant),
        .req_write (req_write),
        .req_addr  (req_addr),
        .fwd_write (fwd_write),
        .fwd_addr  (fwd_addr)
    );

    always_comb fwd_valid = any_grant;

    // next-state: pointer moves past the winner, only when a grant is issued
    always_comb begin
        st_d = st_q;
        if (MODE == ARB_ROTATE && any_grant) begin
            st_d.ptr = (grant_idx == LAST) ? '0 : grant_idx + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // ---------------- assertions ----------------
    a_r1_no_idle_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req_valid) == '0);

    a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    a_r11_work_conserving: assert property (@(posedge clk) disable iff (!rst_n)
        (|eligible) |-> (|grant));

    a_r6_fwd_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !fwd_valid |-> (grant == '0));

    a_r10_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0) |=> $stable(st_q.ptr));

    for (genvar i = 0; i < N; i++) begin : g_chk
        a_r6_fwd_match: assert property (@(posedge clk) disable iff (!rst_n)
            grant[i] |-> (fwd_valid && fwd_write == req_write[i]
                          && fwd_addr == req_addr[i*AW +: AW]));

        a_r3_no_clash_grant: assert property (@(posedge clk) disable iff (!rst_n)
            (grant[i] && busy_valid && req_addr[i*AW +: AW] == busy_addr)
                |-> !(busy_write || req_write[i]));

        if (MODE == ARB_FIXED && i > 0) begin : g_fix
            localparam logic [N-1:0] BELOW = N'((1 << i) - 1);
            a_r7_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
                grant[i] |-> ((eligible & BELOW) == '0));
        end
    end

endmodule

// File: tb/mem_port_arbiter_tb.sv
`timescale 1ns/1ps
module mem_port_arbiter_tb;
    import mem_arb_pkg::*;

    localparam int AW = 4;
    localparam int NF = 3;
    localparam int NR = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // fixed-priority instance
    logic [NF-1:0]    f_rv = '0, f_rw = '0, f_g;
    logic [NF*AW-1:0] f_ra = '0;
    logic f_bv = 1'b0, f_bw = 1'b0;
    logic [AW-1:0] f_ba = '0, f_fa;
    logic f_fv, f_fw;

    mem_port_arbiter #(.N(NF), .AW(AW), .MODE(ARB_FIXED)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(f_rv), .req_write(f_rw), .req_addr(f_ra),
        .busy_valid(f_bv), .busy_write(f_bw), .busy_addr(f_ba),
        .grant(f_g), .fwd_valid(f_fv), .fwd_write(f_fw), .fwd_addr(f_fa)
    );

    // rotating instance
    logic [NR-1:0]    r_rv = '0, r_rw = '0, r_g;
    logic [NR*AW-1:0] r_ra = '0;
    logic r_bv = 1'b0, r_bw = 1'b0;
    logic [AW-1:0] r_ba = '0, r_fa;
    logic r_fv, r_fw;

    mem_port_arbiter #(.N(NR), .AW(AW), .MODE(ARB_ROTATE)) u_rr (
        .clk(clk), .rst_n(rst_n),
        .req_valid(r_rv), .req_write(r_rw), .req_addr(r_ra),
        .busy_valid(r_bv), .busy_write(r_bw), .busy_addr(r_ba),
        .grant(r_g), .fwd_valid(r_fv), .fwd_write(r_fw), .fwd_addr(r_fa)
    );

    typedef struct packed {
        logic [NF-1:0]    rv;
        logic [NF-1:0]    rw;
        logic [NF*AW-1:0] ra;   // {a2,a1,a0}
        logic             bv;
        logic             bw;
        logic [AW-1:0]    ba;
        logic [NF-1:0]    g;
        logic [3:0]       req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TAB [NV] = '{
        '{3'b000, 3'b000, 12'h000, 1'b0, 1'b0, 4'h0, 3'b000, 4'd1},  // R1 all idle
        '{3'b001, 3'b000, 12'h001, 1'b0, 1'b0, 4'h0, 3'b001, 4'd6},  // R6 port0 read
        '{3'b010, 3'b010, 12'h010, 1'b0, 1'b0, 4'h0, 3'b010, 4'd6},  // R6 port1 write
        '{3'b100, 3'b000, 12'h500, 1'b0, 1'b0, 4'h0, 3'b100, 4'd6},  // R6 port2 read
        '{3'b011, 3'b000, 12'h021, 1'b0, 1'b0, 4'h0, 3'b001, 4'd7},  // R7 0+1
        '{3'b110, 3'b000, 12'h210, 1'b0, 1'b0, 4'h0, 3'b010, 4'd7},  // R7 1+2
        '{3'b111, 3'b110, 12'h211, 1'b0, 1'b0, 4'h0, 3'b001, 4'd7},  // R7 read beats writes
        '{3'b011, 3'b000, 12'h021, 1'b1, 1'b1, 4'h1, 3'b010, 4'd3},  // R3 busy write, read same
        '{3'b011, 3'b001, 12'h021, 1'b1, 1'b1, 4'h1, 3'b010, 4'd3},  // R3 write vs write
        '{3'b011, 3'b001, 12'h021, 1'b1, 1'b0, 4'h1, 3'b010, 4'd3},  // R3 write vs busy read
        '{3'b001, 3'b001, 12'h002, 1'b1, 1'b1, 4'h1, 3'b001, 4'd4},  // R4 other address
        '{3'b001, 3'b001, 12'h001, 1'b1, 1'b1, 4'h1, 3'b000, 4'd6},  // R6 only request blocked
        '{3'b011, 3'b000, 12'h021, 1'b1, 1'b0, 4'h1, 3'b001, 4'd5},  // R5 read vs busy read
        '{3'b111, 3'b011, 12'h333, 1'b1, 1'b0, 4'h3, 3'b100, 4'd5}   // R5 writes blocked, read passes
    };

    task automatic check(input string what, input int req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // rotating step: idx = -1 means no grant expected
    task automatic rr_step(input logic [NR-1:0] rv, input logic [NR-1:0] rw,
                           input logic bv, input logic bw, input logic [AW-1:0] ba,
                           input int idx, input int req);
        logic [NR-1:0] eg;
        @(negedge clk);
        r_rv = rv; r_rw = rw; r_bv = bv; r_bw = bw; r_ba = ba;
        #1;
        eg = (idx < 0) ? '0 : NR'(1) << idx;
        check("rr grant", req, int'(r_g), int'(eg));
        check("rr fwd_valid", req, int'(r_fv), (idx < 0) ? 0 : 1);
        if (idx >= 0) begin
            check("rr fwd_addr", req, int'(r_fa), int'(r_ra[idx*AW +: AW]));
            check("rr fwd_write", req, int'(r_fw), int'(rw[idx]));
        end
    endtask

    initial begin
        #(5 * 100000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // reset state: no requests -> no grant (R1, R10)
        #1;
        check("reset grant fixed", 1, int'(f_g), 0);
        check("reset grant rr", 10, int'(r_g), 0);

        // table walk, fixed priority; outputs are combinational (R2)
        for (int v = 0; v < NV; v++) begin
            int efv, efw, efa;
            @(negedge clk);
            f_rv = TAB[v].rv; f_rw = TAB[v].rw; f_ra = TAB[v].ra;
            f_bv = TAB[v].bv; f_bw = TAB[v].bw; f_ba = TAB[v].ba;
            #1;
            efv = 0; efw = 0; efa = 0;
            for (int p = 0; p < NF; p++) begin
                if (TAB[v].g[p]) begin
                    efv = 1; efw = int'(TAB[v].rw[p]); efa = int'(TAB[v].ra[p*AW +: AW]);
                end
            end
            check($sformatf("row %0d grant", v), int'(TAB[v].req), int'(f_g), int'(TAB[v].g));
            check($sformatf("row %0d fwd_valid R6", v), 6, int'(f_fv), efv);
            check($sformatf("row %0d fwd_write R6", v), 6, int'(f_fw), efw);
            check($sformatf("row %0d fwd_addr R6", v), 6, int'(f_fa), efa);
        end

        // R2: same-cycle response on input change between edges
        @(negedge clk);
        f_bv = 1'b0; f_rv = 3'b100; f_ra = 12'h700;
        #0.5;
        check("zero latency grant R2", 2, int'(f_g), 4);
        f_rv = 3'b010;
        #0.5;
        check("zero latency regrant R2", 2, int'(f_g), 2);

        // rotating: addresses a0=1 a1=2 a2=3 a3=4
        r_ra = {4'h4, 4'h3, 4'h2, 4'h1};
        rr_step(4'b1111, 4'b0000, 1'b0, 1'b0, 4'h0, 0, 10); // R10 port 0 first after reset
        rr_step(4'b1111, 4'b0000, 1'b0, 1'b0, 4'h0, 1, 8);  // R8
        rr_step(4'b1111, 4'b0000, 1'b0, 1'b0, 4'h0, 2, 8);
        rr_step(4'b1111, 4'b0000, 1'b0, 1'b0, 4'h0, 3, 8);
        rr_step(4'b1111, 4'b0000, 1'b0, 1'b0, 4'h0, 0, 8);  // R8 wrap
        rr_step(4'b0000, 4'b0000, 1'b0, 1'b0, 4'h0, -1, 10);
        rr_step(4'b0000, 4'b0000, 1'b0, 1'b0, 4'h0, -1, 10);
        rr_step(4'b1111, 4'b0000, 1'b0, 1'b0, 4'h0, 1, 10); // R10 pointer held over idle
        // all-blocked cycle must not move the pointer (R10)
        rr_step(4'b0001, 4'b0001, 1'b1, 1'b0, 4'h1, -1, 10);
        rr_step(4'b1100, 4'b0000, 1'b0, 1'b0, 4'h0, 2, 10);
        rr_step(4'b1000, 4'b0000, 1'b0, 1'b0, 4'h0, 3, 8);  // pointer -> 0
        // R9: port 2 blocked by busy write to address 3
        rr_step(4'b1111, 4'b0010, 1'b1, 1'b1, 4'h3, 0, 9);
        rr_step(4'b1111, 4'b0010, 1'b1, 1'b1, 4'h3, 1, 9);
        rr_step(4'b1111, 4'b0010, 1'b1, 1'b1, 4'h3, 3, 9);
        rr_step(4'b1111, 4'b0010, 1'b1, 1'b1, 4'h3, 0, 9);
        rr_step(4'b1111, 4'b0010, 1'b1, 1'b1, 4'h3, 1, 9);
        // R8 wrap with sparse requests: pointer at 2, only ports 0,1 ask
        rr_step(4'b0011, 4'b0000, 1'b0, 1'b0, 4'h0, 0, 8);
        rr_step(4'b0011, 4'b0000, 1'b0, 1'b0, 4'h0, 1, 8);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule